// File: doc/BRIEF.md
# Paired Output Port Cell

This block drives two adjacent outputs of a crosspoint switch: one even-numbered port and its odd-numbered partner. Each port takes the signal the switch matrix routes to it and produces a pad-level value together with a drive enable. The electrical side of the pad is not modelled. A port either passes its routed signal straight through, captures it in a register, or is cut off from the matrix.

A registered port has two possible clocks. One is the global clock. The other is the routed signal of its partner port, which lets a clock that travels through the switch next to its data strobe that data. Only one port of the pair may use the partner clock at a time. If the configuration asks for both, the cell raises an error flag and clocks both ports from the global clock.

Each port has a five-bit configuration register, loaded through a write strobe with a port select. The drive enable of each port is set by a two-bit code. The code picks one of four behaviours: follow the active-low global enable, follow its inverse, always drive, or never drive.

Top module: `opair_cell`

## Requirements
- R1: The two ports form one fixed pair. The partner clock of port 0 is `mtx_in[1]`, and the partner clock of port 1 is `mtx_in[0]`. A port in flow-through mode forwards the same signal that its partner uses as a clock.
- R2: In registered mode with the global clock (mode 01, clock select 0), `pad_val` shows the routed value sampled at the most recent rising edge of `clk`, and it holds between edges.
- R3: In registered mode with clock select 1, and with no conflict present, a port captures its routed value on the rising edge of its partner's routed signal. Edges of `clk` have no effect on it.
- R4: When both ports have clock select 1, `nbr_err` is high, and every registered port is clocked by `clk` as in R2.
- R5: In flow-through mode (mode 00), `pad_val` follows the port's routed signal without a clock edge.
- R6: In no-connect mode (mode 10 or 11), the port drives `pad_val` = 0 and `pad_en` = 0.
- R7: Outside no-connect mode, the enable code sets `pad_en` as follows: 00 gives `!oe_n_glb`, 01 gives `oe_n_glb`, 10 gives 1, and 11 gives 0.
- R8: After reset, both ports are in flow-through mode on the global clock with enable code 10, and `nbr_err` is low.
- R9: On a rising edge of `clk` with `cfg_we` high, the port chosen by `cfg_sel` loads `cfg_data`. The fields are mode in [1:0], clock select in [2] and enable code in [4:3]. The new setting acts from that edge on. With `cfg_we` low, both configurations stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock for configuration and global-clock registers |
| rst_n | input | 1 | Synchronous active-low reset (reset-all) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Port chosen by a write (0 even, 1 odd) |
| cfg_data | input | 5 | Configuration word: mode [1:0], clock select [2], enable code [4:3] |
| oe_n_glb | input | 1 | Global output enable, active low |
| mtx_in | input | 2 | Routed matrix signal per port |
| pad_val | output | 2 | Output value per port |
| pad_en | output | 2 | Drive enable per port |
| nbr_err | output | 1 | Both ports request the partner clock |

## Verification
The bench builds the cell with its default parameters: a pair of ports whose reset setting is flow-through with the enable always on. With these values the whole configuration space of one pair can be reached. That covers every mode, every enable code against both levels of the global enable, partner clocking in both directions, and the conflict case in which both ports request the partner clock. The bench drives partner-clock edges between global edges. This separates the two clock sources, because a port on the wrong clock then shows a stale value.

// File: rtl/opair_pkg.sv
// Shared types for the paired output port cell.
// Assumes a pair has exactly two ports; the field order of port_cfg_t
// fixes the bit layout of a configuration write.
package opair_pkg;

    typedef enum logic [1:0] {
        MODE_FLOW   = 2'b00,
        MODE_REG    = 2'b01,
        MODE_NC     = 2'b10,
        MODE_NC_ALT = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        OE_GLB     = 2'b00,
        OE_GLB_INV = 2'b01,
        OE_ON      = 2'b10,
        OE_OFF     = 2'b11
    } oe_e;

    typedef struct packed {
        oe_e   oe;       // [4:3]
        logic  nbr_clk;  // [2]
        mode_e mode;     // [1:0]
    } port_cfg_t;

    localparam int CFG_W  = $bits(port_cfg_t);
    localparam int NPORTS = 2;
    localparam int SEL_W  = $clog2(NPORTS);

    localparam port_cfg_t CFG_RESET = '{oe: OE_ON, nbr_clk: 1'b0, mode: MODE_FLOW};

endpackage

// File: rtl/opair_cfg_reg.sv
// Per-port configuration register.
// Loads din on a clock edge with we high; otherwise holds. Reset value
// comes from RST_CFG. Reset is synchronous and active low.
module opair_cfg_reg
    import opair_pkg::*;
#(
    parameter port_cfg_t RST_CFG = CFG_RESET
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  port_cfg_t din,
    output port_cfg_t q
);

    // Hold or load the port setting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_CFG;
        else if (we)
            q <= din;
    end

endmodule

// File: rtl/opair_port.sv
// One output port datapath.
// Keeps two capture registers: one on the global clock and one on the
// partner's routed signal. The output chooses between them, so no clock
// is ever multiplexed. The partner-clocked register has no reset. It is
// only observed in partner-clocked registered mode, after a partner edge.
module opair_port
    import opair_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  d,
    input  logic  nbr_src,
    input  mode_e mode,
    input  oe_e   oe,
    input  logic  use_nbr,
    input  logic  oe_n_glb,
    output logic  val,
    output logic  en
);

    logic q_glb;
    logic q_nbr;

    // Capture on the global clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_glb <= 1'b0;
        else
            q_glb <= d;
    end

    // Capture on the partner's routed signal.
    always_ff @(posedge nbr_src) begin
        q_nbr <= d;
    end

    // Select the output value according to the mode.
    always_comb begin
        unique case (mode)
            MODE_FLOW: val = d;
            MODE_REG:  val = use_nbr ? q_nbr : q_glb;
            default:   val = 1'b0;
        endcase
    end

    // Derive the drive enable from the code and the global enable.
    always_comb begin
        if (mode == MODE_NC || mode == MODE_NC_ALT)
            en = 1'b0;
        else begin
            unique case (oe)
                OE_GLB:     en = ~oe_n_glb;
                OE_GLB_INV: en = oe_n_glb;
                OE_ON:      en = 1'b1;
                default:    en = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/opair_cell.sv
// Paired output port cell: an even/odd pair of output ports.
// Each port takes the partner's routed signal as its optional clock.
// When both ports ask for the partner clock, the cell flags an error and
// falls back to the global clock for both.
module opair_cell
    import opair_pkg::*;
#(
    parameter port_cfg_t RST_CFG = CFG_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              oe_n_glb,
    input  logic [NPORTS-1:0] mtx_in,
    output logic [NPORTS-1:0] pad_val,
    output logic [NPORTS-1:0] pad_en,
    output logic              nbr_err
);

    port_cfg_t cfg_q [NPORTS];
    logic      conflict;

    // Flag a pair in which both ports request the partner clock.
    always_comb begin
        conflict = cfg_q[0].nbr_clk & cfg_q[1].nbr_clk;
    end

    assign nbr_err = conflict;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic wr_hit;
        logic use_nbr;

        // Decode a write to this port.
        always_comb begin
            wr_hit = cfg_we && (cfg_sel == p[SEL_W-1:0]);
        end

        // Allow the partner clock only without a conflict.
        always_comb begin
            use_nbr = cfg_q[p].nbr_clk & ~conflict;
        end

        opair_cfg_reg #(
            .RST_CFG (RST_CFG)
        ) u_cfg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_hit),
            .din   (port_cfg_t'(cfg_data)),
            .q     (cfg_q[p])
        );

        opair_port u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .d        (mtx_in[p]),
            .nbr_src  (mtx_in[p ^ 1]),
            .mode     (cfg_q[p].mode),
            .oe       (cfg_q[p].oe),
            .use_nbr  (use_nbr),
            .oe_n_glb (oe_n_glb),
            .val      (pad_val[p]),
            .en       (pad_en[p])
        );
    end

endmodule

// File: rtl/opair_cell_chk.sv
// Property checker for opair_cell, attached by bind below.
// Observes the two configuration registers alongside the pads.
module opair_cell_chk
    import opair_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cfg_we,
    input logic      oe_n_glb,
    input logic [1:0] mtx_in,
    input logic [1:0] pad_val,
    input logic [1:0] pad_en,
    input logic      nbr_err,
    input port_cfg_t cfg0,
    input port_cfg_t cfg1
);

    // No-connect port is silent.
    assert_nc_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg0.mode == MODE_NC || cfg0.mode == MODE_NC_ALT) |-> (pad_en[0] == 1'b0 && pad_val[0] == 1'b0));

    // Code 11 never drives; code 10 always drives outside no-connect.
    assert_oe_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg1.oe == OE_OFF) |-> !pad_en[1]);
    assert_oe_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg0.oe == OE_GLB && cfg0.mode == MODE_FLOW) |-> (pad_en[0] == !oe_n_glb));

    // Global-clock registered port shows the last sampled value.
    assert_reg_glb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cfg0.mode == MODE_REG && !cfg0.nbr_clk
         && $past(cfg0.mode) == MODE_REG && !$past(cfg0.nbr_clk))
        |-> pad_val[0] == $past(mtx_in[0]));

    // With a conflict both registered ports run on the global clock.
    assert_conflict_glb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && nbr_err && $past(nbr_err)
         && cfg1.mode == MODE_REG && $past(cfg1.mode) == MODE_REG)
        |-> pad_val[1] == $past(mtx_in[1]));

    // Without a write strobe nothing in the configuration moves.
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(cfg0) && $stable(cfg1)));

endmodule

bind opair_cell opair_cell_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .oe_n_glb (oe_n_glb),
    .mtx_in   (mtx_in),
    .pad_val  (pad_val),
    .pad_en   (pad_en),
    .nbr_err  (nbr_err),
    .cfg0     (cfg_q[0]),
    .cfg1     (cfg_q[1])
);

// File: tb/opair_cell_tb.sv
`timescale 1ns/1ps
module opair_cell_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [4:0] cfg_data = '0;
    logic       oe_n_glb = 1'b0;
    logic [1:0] mtx_in = '0;
    logic [1:0] pad_val;
    logic [1:0] pad_en;
    logic       nbr_err;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    opair_cell u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .oe_n_glb (oe_n_glb),
        .mtx_in   (mtx_in),
        .pad_val  (pad_val),
        .pad_en   (pad_en),
        .nbr_err  (nbr_err)
    );

    // Row layout: {oe[1:0], mode[1:0], oe_n_glb, d, exp_val, exp_en}
    localparam logic [7:0] VEC [12] = '{
        8'b00_00_0_1_1_1,  // R7 follow, enabled
        8'b00_00_1_1_1_0,  // R7 follow, disabled
        8'b01_00_0_0_0_0,  // R7 inverted
        8'b01_00_1_1_1_1,  // R7 inverted
        8'b10_01_1_1_1_1,  // R2 registered, always on
        8'b11_01_0_1_1_0,  // R7 always off
        8'b10_10_0_1_0_0,  // R6 no-connect
        8'b00_10_0_1_0_0,  // R6 no-connect
        8'b10_00_0_0_0_1,  // R5 flow low
        8'b11_00_1_1_1_0,  // R7 always off
        8'b00_01_0_0_0_1,  // R2 registered low
        8'b10_11_0_1_0_0   // R6 alternate no-connect
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [4:0] c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = c;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mtx_in = 2'b10;
        #1;
        // R8: reset state is flow-through with enable on
        check("R8 val", pad_val[1] == 1'b1 && pad_val[0] == 1'b0, 1'b1);
        check("R8 en", pad_en == 2'b11, 1'b1);
        check("R8 err", nbr_err, 1'b0);

        // Table walk on both ports.
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 12; i++) begin
                wr(p[0], {VEC[i][7:6], 1'b0, VEC[i][5:4]});
                oe_n_glb = VEC[i][3];
                mtx_in = '0;
                mtx_in[p] = VEC[i][2];
                @(posedge clk); #2;
                check("R5/R6/R7/R9 val", pad_val[p], VEC[i][1]);
                check("R6/R7/R9 en", pad_en[p], VEC[i][0]);
            end
        end

        // R3 and R1: port 0 clocked by port 1's routed signal.
        oe_n_glb = 1'b0;
        wr(1'b1, 5'b10_0_00);
        wr(1'b0, 5'b10_1_01);
        mtx_in = 2'b00;
        #1 mtx_in[1] = 1'b1;
        #1 mtx_in[1] = 1'b0; mtx_in[0] = 1'b1;
        #1 check("R3 before partner edge", pad_val[0], 1'b0);
        check("R4 no conflict", nbr_err, 1'b0);
        #1 mtx_in[1] = 1'b1;
        #1 check("R3 after partner edge", pad_val[0], 1'b1);
        check("R1 partner forwards clock", pad_val[1], 1'b1);
        @(negedge clk) mtx_in[0] = 1'b0;
        @(posedge clk); #2;
        check("R3 global edge ignored", pad_val[0], 1'b1);

        // R1: port 1 clocked by port 0's routed signal.
        wr(1'b0, 5'b10_0_00);
        wr(1'b1, 5'b10_1_01);
        mtx_in = 2'b00;
        #1 mtx_in[0] = 1'b1;
        #1 mtx_in[0] = 1'b0; mtx_in[1] = 1'b1;
        #1 mtx_in[0] = 1'b1;
        #1 check("R1 port1 on port0 edge", pad_val[1], 1'b1);
        @(negedge clk) mtx_in[1] = 1'b0;
        @(posedge clk); #2;
        check("R1 port1 ignores clk", pad_val[1], 1'b1);

        // R4: both request partner clock.
        wr(1'b0, 5'b10_1_01);
        check("R4 error flag", nbr_err, 1'b1);
        @(negedge clk) mtx_in = 2'b01;
        @(posedge clk); #2;
        check("R4 port0 global", pad_val[0], 1'b1);
        check("R4 port1 global", pad_val[1], 1'b0);
        #1 mtx_in[0] = 1'b0;
        #1 mtx_in[1] = 1'b1;
        #1 check("R4 partner edge ignored", pad_val[0], 1'b1);
        check("R4 port1 held", pad_val[1], 1'b0);

        // R2 and R5: registered hold next to a flow port.
        wr(1'b1, 5'b10_0_00);
        wr(1'b0, 5'b10_0_01);
        check("R4 error cleared", nbr_err, 1'b0);
        @(negedge clk) mtx_in = 2'b01;
        @(posedge clk); #2;
        check("R2 captured", pad_val[0], 1'b1);
        #1 mtx_in = 2'b10;
        #1 check("R2 held between edges", pad_val[0], 1'b1);
        check("R5 flow follows", pad_val[1], 1'b1);

        // R9: data without the strobe is ignored.
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 1'b0; cfg_data = 5'b11_0_10;
        mtx_in = 2'b01;
        @(posedge clk); #2;
        check("R9 no strobe val", pad_val[0], 1'b1);
        check("R9 no strobe en", pad_en[0], 1'b1);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule